// File: doc/BRIEF.md
# Differential Reed–Solomon Parity Updater

This block keeps the four parity symbols of a systematic Reed–Solomon codeword up to date when only a few data symbols change. It does not re-encode the whole codeword. The host first loads the codeword's current parity. It then streams one record per changed data symbol: the symbol's position, its old value and its new value. For each record the block multiplies the difference (old XOR new) by the parity coefficients that belong to that position. It then XORs the result into a running parity. Because encoding is linear, this gives the same parity as encoding the modified data from scratch.

An end command closes the update, and the block then presents the accumulated parity. Several records, including repeated hits on one position, fold into a single result. Back-to-back updates need no idle cycle between them. The per-position coefficients come from a table that is computed at elaboration from the generator polynomial.

Top module: `rsd_parity_update`

## Requirements
- R1: After reset, out_valid_o is 0, out_parity_o is 0 and no update is open.
- R2: A command with op 2'd0 (load) sets the running parity to cmd_parity_i and opens an update. A load while an update is open discards the earlier accumulation. Parity byte i (bits 8i+7..8i) is the coefficient of x^i of the remainder.
- R3: A command with op 2'd1 (record) at position j < 251 XORs (old ^ new) · (x^(j+4) mod g(x)) into the running parity, one record per cycle. GF(2^8) uses polynomial 0x11D and g(x) = (x+1)(x+2)(x+4)(x+8). For j = 0 and a difference of 1, the contribution is 32'h0F367840.
- R4: A record whose old and new values are equal leaves the parity unchanged.
- R5: Any number of records, including several to the same position, accumulate. If the loaded parity was the encoding of the original data, the result equals a full systematic re-encode of the modified data, where data symbol j sits at x^(j+4).
- R6: A command with op 2'd2 (end) while an update is open raises out_valid_o for exactly one cycle, starting the cycle after the end command. At the same time out_parity_o shows the accumulated parity and the update closes.
- R7: An end command, or a record, with no update open has no effect; out_valid_o stays 0.
- R8: A record with position 251 or higher leaves the parity unchanged.
- R9: Op 2'd3 and cycles with cmd_valid_i low have no effect.
- R10: out_parity_o holds its value until the next valid end command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 load, 1 record, 2 end, 3 no-op |
| cmd_parity_i | input | 32 | Parity to load (op 0) |
| cmd_pos_i | input | 8 | Data symbol position (op 1) |
| cmd_old_i | input | 8 | Previous symbol value (op 1) |
| cmd_new_i | input | 8 | Replacement symbol value (op 1) |
| out_valid_o | output | 1 | Updated parity valid, one-cycle pulse |
| out_parity_o | output | 32 | Updated parity, byte i = coefficient of x^i |

## Verification
The bench loads the parity of random codewords and applies sparse edits. It then compares every result against a full re-encode of the edited data. A wrong coefficient table, a wrong power offset or a wrong field multiply would therefore give mismatched bytes. Position 0 and position 250 are both exercised, because an off-by-one in the table indexing corrupts exactly those edges. Repeated edits to one position and edits with equal old and new values are included, since a design that overwrites instead of XORing would lose the earlier edit. Out-of-range positions, stray end commands, the no-op code, a reload during an open update and an end followed at once by a new load are checked cycle by cycle. A design that leaks any of these into the parity, or that pulses out_valid_o wrongly, is caught.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int SYM_W = 8;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_REC  = 2'd1,
        OP_END  = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    // Carry-less multiply in GF(2^SYM_W), reducing with poly_low
    // (the field polynomial without its top bit).
    function automatic sym_t gf_mul(input sym_t a, input sym_t b, input sym_t poly_low);
        sym_t prod;
        sym_t x;
        prod = '0;
        x    = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) prod = prod ^ x;
            if (x[SYM_W-1]) x = {x[SYM_W-2:0], 1'b0} ^ poly_low;
            else            x = {x[SYM_W-2:0], 1'b0};
        end
        return prod;
    endfunction

endpackage

// File: rtl/rsd_coef_rom.sv
// Per-position parity coefficients: entry j holds x^(j+NPAR) mod g(x),
// g(x) = prod_{r<NPAR} (x + alpha^r), alpha = 2. Built at elaboration.
module rsd_coef_rom
    import rsd_pkg::*;
#(
    parameter int   NPAR     = 4,
    parameter int   NDATA    = 251,
    parameter int   POS_W    = 8,
    parameter sym_t POLY_LOW = 8'h1D
) (
    input  logic [POS_W-1:0]            pos_i,
    output logic [NPAR-1:0][SYM_W-1:0]  coef_o
);

    typedef logic [NPAR-1:0][SYM_W-1:0] coefs_t;
    typedef coefs_t [NDATA-1:0]         table_t;

    function automatic table_t build_table();
        table_t                   tab;
        logic [NPAR:0][SYM_W-1:0] gen;
        coefs_t                   rem;
        sym_t                     root;
        sym_t                     top;
        gen    = '0;
        gen[0] = sym_t'(1);
        root   = sym_t'(1);
        for (int r = 0; r < NPAR; r++) begin
            for (int i = NPAR; i >= 1; i--) begin
                gen[i] = gen[i-1] ^ gf_mul(gen[i], root, POLY_LOW);
            end
            gen[0] = gf_mul(gen[0], root, POLY_LOW);
            root   = gf_mul(root, sym_t'(2), POLY_LOW);
        end
        // x^NPAR mod g equals the lower generator coefficients (char 2)
        for (int i = 0; i < NPAR; i++) rem[i] = gen[i];
        for (int j = 0; j < NDATA; j++) begin
            tab[j] = rem;
            top    = rem[NPAR-1];
            for (int i = NPAR - 1; i >= 1; i--) begin
                rem[i] = rem[i-1] ^ gf_mul(top, gen[i], POLY_LOW);
            end
            rem[0] = gf_mul(top, gen[0], POLY_LOW);
        end
        return tab;
    endfunction

    localparam table_t COEF_TABLE = build_table();
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NDATA - 1);

    always_comb begin
        if (pos_i <= LAST_POS) coef_o = COEF_TABLE[pos_i];
        else                   coef_o = '0;
    end

endmodule

// File: rtl/rsd_delta_mac.sv
// Multiplies a symbol difference by NPAR coefficients and folds the
// products into the running parity.
module rsd_delta_mac
    import rsd_pkg::*;
#(
    parameter int   NPAR     = 4,
    parameter sym_t POLY_LOW = 8'h1D,
    localparam int  PAR_W    = NPAR * SYM_W
) (
    input  sym_t                        old_i,
    input  sym_t                        new_i,
    input  logic [NPAR-1:0][SYM_W-1:0]  coef_i,
    input  logic [PAR_W-1:0]            acc_i,
    output logic [PAR_W-1:0]            acc_o
);

    sym_t delta;
    assign delta = old_i ^ new_i;

    for (genvar k = 0; k < NPAR; k++) begin : g_lane
        assign acc_o[k*SYM_W +: SYM_W] =
            acc_i[k*SYM_W +: SYM_W] ^ gf_mul(delta, coef_i[k], POLY_LOW);
    end

endmodule

// File: rtl/rsd_parity_update.sv
module rsd_parity_update
    import rsd_pkg::*;
#(
    parameter int  NSYM       = 255,
    parameter int  NPAR       = 4,
    parameter int  FIELD_POLY = 'h11D,
    localparam int NDATA      = NSYM - NPAR,
    localparam int POS_W      = $clog2(NSYM + 1),
    localparam int PAR_W      = NPAR * SYM_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [PAR_W-1:0]  cmd_parity_i,
    input  logic [POS_W-1:0]  cmd_pos_i,
    input  logic [SYM_W-1:0]  cmd_old_i,
    input  logic [SYM_W-1:0]  cmd_new_i,
    output logic              out_valid_o,
    output logic [PAR_W-1:0]  out_parity_o
);

    localparam sym_t POLY_LOW = sym_t'(FIELD_POLY % (1 << SYM_W));

    typedef struct packed {
        logic             busy;
        logic [PAR_W-1:0] acc;
        logic             vld;
        logic [PAR_W-1:0] par;
    } state_t;

    state_t                     st_d, st_q;
    logic [NPAR-1:0][SYM_W-1:0] coef;
    logic [PAR_W-1:0]           mac_acc;

    rsd_coef_rom #(
        .NPAR     (NPAR),
        .NDATA    (NDATA),
        .POS_W    (POS_W),
        .POLY_LOW (POLY_LOW)
    ) i_rom (
        .pos_i  (cmd_pos_i),
        .coef_o (coef)
    );

    rsd_delta_mac #(
        .NPAR     (NPAR),
        .POLY_LOW (POLY_LOW)
    ) i_mac (
        .old_i  (cmd_old_i),
        .new_i  (cmd_new_i),
        .coef_i (coef),
        .acc_i  (st_q.acc),
        .acc_o  (mac_acc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (cmd_valid_i) begin
            case (op_e'(cmd_op_i))
                OP_LOAD: begin
                    st_d.busy = 1'b1;
                    st_d.acc  = cmd_parity_i;
                end
                OP_REC: begin
                    if (st_q.busy) st_d.acc = mac_acc;
                end
                OP_END: begin
                    if (st_q.busy) begin
                        st_d.vld  = 1'b1;
                        st_d.par  = st_q.acc;
                        st_d.busy = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_valid_o  = st_q.vld;
    assign out_parity_o = st_q.par;

    assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_LOAD) |=> st_q.acc == $past(cmd_parity_i));

    assert_equal_symbols_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_REC && cmd_old_i == cmd_new_i) |=> $stable(st_q.acc));

    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |=> !out_valid_o);

    assert_idle_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_END && !st_q.busy) |=> !out_valid_o);

    assert_out_of_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_REC && cmd_pos_i >= POS_W'(NDATA)) |=> $stable(st_q.acc));

    assert_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_NONE) |=> ($stable(st_q.acc) && !out_valid_o));

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> $stable(out_parity_o));

endmodule

// File: tb/test_rsd_parity_update.sv
module test_rsd_parity_update;

    localparam int K = 251;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd3;
    logic [31:0] cmd_parity = '0;
    logic [7:0]  cmd_pos = '0;
    logic [7:0]  cmd_old = '0;
    logic [7:0]  cmd_new = '0;
    logic        out_valid;
    logic [31:0] out_parity;

    always #2 clk = ~clk;

    rsd_parity_update i_rsd_parity_update (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .cmd_parity_i (cmd_parity),
        .cmd_pos_i    (cmd_pos),
        .cmd_old_i    (cmd_old),
        .cmd_new_i    (cmd_new),
        .out_valid_o  (out_valid),
        .out_parity_o (out_parity)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int          gen [5];
    int          base [K];
    int          cur [K];
    bit          m_open = 0;
    logic [31:0] m_load = '0;
    logic        exp_v = 0;
    logic [31:0] exp_p = '0;

    function automatic int gmul(input int a, input int b);
        int r = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if (((b >> i) & 1) != 0) r = r ^ x;
            x = x << 1;
            if ((x & 'h100) != 0) x = x ^ 'h11D;
        end
        return r;
    endfunction

    // Full systematic encode: long division of data(x)*x^4 by gen(x)
    function automatic logic [31:0] encode(input int d [K]);
        int rem [4];
        int fb;
        for (int i = 0; i < 4; i++) rem[i] = 0;
        for (int j = K - 1; j >= 0; j--) begin
            fb     = d[j] ^ rem[3];
            rem[3] = rem[2] ^ gmul(fb, gen[3]);
            rem[2] = rem[1] ^ gmul(fb, gen[2]);
            rem[1] = rem[0] ^ gmul(fb, gen[1]);
            rem[0] = gmul(fb, gen[0]);
        end
        return {rem[3][7:0], rem[2][7:0], rem[1][7:0], rem[0][7:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] par,
                        input int pos, input int o, input int n, input string tag);
        cmd_valid  = v;
        cmd_op     = op;
        cmd_parity = par;
        cmd_pos    = pos[7:0];
        cmd_old    = o[7:0];
        cmd_new    = n[7:0];
        @(posedge clk);
        exp_v = 1'b0;
        if (v) begin
            case (op)
                2'd0: begin m_open = 1; m_load = par; cur = base; end
                2'd1: if (m_open && pos < K) cur[pos] = cur[pos] ^ o ^ n;
                2'd2: if (m_open) begin
                    exp_v  = 1'b1;
                    exp_p  = m_load ^ encode(base) ^ encode(cur);
                    m_open = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check(out_valid === exp_v, {tag, " valid"}, {31'd0, out_valid}, {31'd0, exp_v});
        check(out_parity === exp_p, {tag, " parity"}, out_parity, exp_p);
    endtask

    task automatic load(input logic [31:0] p, input string tag);
        step(1, 2'd0, p, 0, 0, 0, tag);
    endtask
    task automatic rec(input int pos, input int o, input int n, input string tag);
        step(1, 2'd1, '0, pos, o, n, tag);
    endtask
    task automatic fin(input string tag);
        step(1, 2'd2, '0, 0, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 2'd1, 32'hDEAD_BEEF, 3, 1, 2, tag);
    endtask

    initial begin
        int root;
        gen[0] = 1;
        for (int i = 1; i < 5; i++) gen[i] = 0;
        root = 1;
        for (int r = 0; r < 4; r++) begin
            for (int i = 4; i >= 1; i--) gen[i] = gen[i-1] ^ gmul(gen[i], root);
            gen[0] = gmul(gen[0], root);
            root   = gmul(root, 2);
        end
        for (int j = 0; j < K; j++) base[j] = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 valid", {31'd0, out_valid}, 32'd0);
        check(out_parity === 32'd0, "R1 parity", out_parity, 32'd0);
        rst_n = 1'b1;
        idle("R1 idle");

        // R3: single unit difference at position 0 gives known remainder
        load(32'd0, "R3 load");
        rec(0, 0, 1, "R3 rec");
        fin("R3 end");
        check(out_parity === 32'h0F367840, "R3 const", out_parity, 32'h0F367840);

        // R7 / R9: stray end, stray record, no-op and invalid cycles
        fin("R7 idle end");
        rec(5, 0, 9, "R7 idle rec");
        step(1, 2'd3, 32'h1234_5678, 1, 0, 7, "R9 noop");
        idle("R10 hold");

        // R4 / R8: equal values and out-of-range positions leave parity alone
        for (int j = 0; j < K; j++) base[j] = $urandom_range(0, 255);
        load(encode(base), "R4 load");
        rec(17, 'h5A, 'h5A, "R4 equal");
        rec(251, 0, 'hFF, "R8 pos251");
        rec(255, 3, 'h80, "R8 pos255");
        step(1, 2'd3, 32'hFFFF_FFFF, 2, 0, 1, "R9 noop open");
        idle("R9 invalid");
        fin("R4 end");
        check(out_parity === encode(base), "R4 unchanged", out_parity, encode(base));

        // R2: reload during an open update discards earlier records
        load(32'hA5A5_A5A5, "R2 load1");
        rec(100, 0, 'h33, "R2 rec");
        load(encode(base), "R2 reload");
        rec(250, base[250], base[250] ^ 'h01, "R2 rec edge");
        fin("R2 end");

        // R5: repeated edits to one position, edges, back-to-back updates
        load(encode(base), "R5 load");
        rec(0, base[0], 'h11, "R5 pos0");
        rec(0, 'h11, 'h22, "R5 pos0 again");
        rec(250, base[250], 'hC3, "R5 pos250");
        fin("R5 end");
        load(32'h0102_0304, "R5 btb load");
        rec(42, 7, 9, "R5 btb rec");
        fin("R5 btb end");
        repeat (3) idle("R10 hold");

        // R5 / R6: random codewords compared against full re-encode
        for (int t = 0; t < 40; t++) begin
            int nrec;
            int pos;
            int nv;
            for (int j = 0; j < K; j++) base[j] = $urandom_range(0, 255);
            load(encode(base), "R5 rnd load");
            nrec = $urandom_range(1, 10);
            for (int r = 0; r < nrec; r++) begin
                pos = $urandom_range(0, 255);
                nv  = $urandom_range(0, 255);
                if (pos < K) rec(pos, cur[pos], nv, "R5 rnd rec");
                else         rec(pos, 0, nv, "R8 rnd rec");
            end
            fin("R6 rnd end");
            if (t % 3 == 0) idle("R10 rnd hold");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule